// File: doc/BRIEF.md
# Halfword DMA Residue Buffer

This block is a single DMA channel that moves a stream of 16-bit halfwords between a device and a memory port that only takes whole, aligned 8-byte blocks. A 64-bit residue register, which software reads and writes as two 32-bit words, and a 2-bit halfword pointer deal with unaligned starts and ends. No byte-enabled memory write is ever needed.

For device-to-memory moves, software sets the block address to the start address rounded down to 8 bytes. It preloads the residue with the memory contents of that block and points the pointer at the first halfword to overwrite. The engine fills halfwords into the residue and writes each completed block. A trailing partial block stays in the residue, so software can patch it in afterwards. For memory-to-device moves, the preloaded residue supplies the first halfwords starting at the pointer, and later blocks are fetched from the block address. Halfwords are little-endian in a block: halfword 0 sits in bits 15:0.

Register map (3-bit offset): 0 residue bits 31:0, 1 residue bits 63:32, 2 pointer (bits 1:0), 3 block address (low 3 bits forced to 0), 4 length in halfwords, 5 control. On a write to control, bit 0 starts a transfer and bit 1 selects the direction (1 = memory to device). On a read of control, bit 0 is busy, bit 1 is direction and bit 2 is done.

Top module: `dma_res_buf`

## Requirements
- R1: After reset every register reads 0, done_o is low, and mem_req_o, dev_in_ready_o and dev_out_valid_o are low.
- R2: In device-to-memory mode, each accepted input halfword is stored in residue halfword `pointer` (bits 16*p+15:16*p), and the pointer then advances modulo 4.
- R3: When the halfword at pointer 3 is filled, the block is written to the block address. Halfwords below the starting pointer keep their preloaded values. The address then steps by 8, and no input is accepted while the write is pending.
- R4: When the length runs out in device-to-memory mode, a block with fewer than four new halfwords is not written. The pointer reads the count of halfwords (0 to 3) held in the residue, and the block address reads the block still to be completed.
- R5: In memory-to-device mode, the output halfword is residue halfword `pointer`. It is held until accepted, and the pointer then advances modulo 4.
- R6: In memory-to-device mode, after halfword 3 is sent and more data remains, one block is read from the block address into the residue. The pointer restarts at 0 and the address steps by 8. No block is read once the length has run out.
- R7: When the programmed number of halfwords has moved, done is set and busy clears. The residue, pointer and address then stay unchanged until the next start, which clears done.
- R8: While busy, writes to any register, including a new start, have no effect.
- R9: A start with length 0 sets done on the next cycle without any memory or device activity.
- R10: A memory request holds its address, direction and data stable until mem_ack_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| dev_in_valid_i | input | 1 | Device halfword valid (device to memory) |
| dev_in_data_i | input | 16 | Device halfword |
| dev_in_ready_o | output | 1 | Block accepts a device halfword |
| dev_out_valid_o | output | 1 | Halfword to device valid (memory to device) |
| dev_out_data_o | output | 16 | Halfword to device |
| dev_out_ready_i | input | 1 | Device accepts the halfword |
| mem_req_o | output | 1 | Block memory request |
| mem_we_o | output | 1 | 1 = write block, 0 = read block |
| mem_addr_o | output | ADDR_W | 8-byte aligned block address |
| mem_wdata_o | output | 64 | Block write data |
| mem_rdata_i | input | 64 | Block read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Completes the current memory request |
| done_o | output | 1 | Transfer finished |

## Verification
The bench builds the block with a 12-bit address and a 6-bit length. The narrow address lets a transfer that starts near the top of the space wrap the block address back to zero. The narrow length makes the maximum count of 63 halfwords reachable. Directed transfers check exact memory images, head merges and tail residue against hand-worked values. Random transfers vary the pointer, the length and the stall patterns on the device and memory sides. A behavioural model predicts every output on every cycle.

// File: rtl/dma_res_pkg.sv
package dma_res_pkg;
  localparam int HW_W    = 16;
  localparam int N_HW    = 4;
  localparam int BLK_W   = HW_W * N_HW;
  localparam int PTR_W   = $clog2(N_HW);
  localparam int BLK_OFF = $clog2(BLK_W / 8);

  localparam logic [2:0] REG_RES_LO = 3'd0;
  localparam logic [2:0] REG_RES_HI = 3'd1;
  localparam logic [2:0] REG_PTR    = 3'd2;
  localparam logic [2:0] REG_ADDR   = 3'd3;
  localparam logic [2:0] REG_LEN    = 3'd4;
  localparam logic [2:0] REG_CTRL   = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_MEM} xfer_state_e;
endpackage

// File: rtl/dma_res_store.sv
module dma_res_store
  import dma_res_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sw_we_i,
  input  logic [31:0]      sw_wdata_i,
  input  logic             hw_we_i,
  input  logic [PTR_W-1:0] hw_idx_i,
  input  logic [HW_W-1:0]  hw_data_i,
  input  logic             blk_we_i,
  input  logic [BLK_W-1:0] blk_data_i,
  output logic [BLK_W-1:0] res_o
);
  localparam int HW_PER_WORD = 32 / HW_W;

  for (genvar i = 0; i < N_HW; i++) begin : g_hw
    logic [HW_W-1:0] hw_q;
    // block load wins over stream fill, stream over software
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hw_q <= '0;
      else if (blk_we_i) hw_q <= blk_data_i[i*HW_W +: HW_W];
      else if (hw_we_i && hw_idx_i == PTR_W'(i)) hw_q <= hw_data_i;
      else if (sw_we_i[i/HW_PER_WORD])
        hw_q <= sw_wdata_i[(i%HW_PER_WORD)*HW_W +: HW_W];
    end
    assign res_o[i*HW_W +: HW_W] = hw_q;
  end
endmodule

// File: rtl/dma_res_ctrl.sv
module dma_res_ctrl
  import dma_res_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      dir_i,
  input  logic                      ptr_we_i,
  input  logic [PTR_W-1:0]          ptr_wdata_i,
  input  logic                      addr_we_i,
  input  logic [ADDR_W-1:BLK_OFF]   addr_wdata_i,
  input  logic                      len_we_i,
  input  logic [LEN_W-1:0]          len_wdata_i,
  input  logic                      dev_in_valid_i,
  input  logic                      dev_out_ready_i,
  input  logic                      mem_ack_i,
  output logic                      busy_o,
  output logic                      dir_o,
  output logic                      done_o,
  output logic [PTR_W-1:0]          ptr_o,
  output logic [ADDR_W-1:0]         blk_addr_o,
  output logic [LEN_W-1:0]          len_o,
  output logic                      hw_we_o,
  output logic                      blk_we_o,
  output logic                      dev_in_ready_o,
  output logic                      dev_out_valid_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_HW - 1);

  xfer_state_e                state_q;
  logic [PTR_W-1:0]           ptr_q;
  logic [ADDR_W-1:BLK_OFF]    blk_q;
  logic [LEN_W-1:0]           len_q, cnt_q;
  logic                       dir_q, done_q;
  logic                       step, last;

  assign step = (state_q == ST_XFER) && (dir_q ? dev_out_ready_i : dev_in_valid_i);
  assign last = (cnt_q == LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      blk_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ptr_we_i)  ptr_q <= ptr_wdata_i;
          if (addr_we_i) blk_q <= addr_wdata_i;
          if (len_we_i)  len_q <= len_wdata_i;
          if (start_i) begin
            dir_q  <= dir_i;
            cnt_q  <= len_q;
            done_q <= (len_q == '0);
            if (len_q != '0) state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (step) begin
            ptr_q <= ptr_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
            if (dir_q) begin
              // no fetch once the count is spent
              if (last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end else if (ptr_q == PTR_LAST) begin
                state_q <= ST_MEM;
              end
            end else begin
              // a full block is flushed even on the final halfword
              if (ptr_q == PTR_LAST) begin
                state_q <= ST_MEM;
              end else if (last) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
        end
        ST_MEM: begin
          if (mem_ack_i) begin
            blk_q <= blk_q + 1'b1;
            if (!dir_q && cnt_q == '0) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              state_q <= ST_XFER;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign dir_o           = dir_q;
  assign done_o          = done_q;
  assign ptr_o           = ptr_q;
  assign blk_addr_o      = {blk_q, {BLK_OFF{1'b0}}};
  assign len_o           = len_q;
  assign hw_we_o         = step && !dir_q;
  assign blk_we_o        = (state_q == ST_MEM) && dir_q && mem_ack_i;
  assign dev_in_ready_o  = (state_q == ST_XFER) && !dir_q;
  assign dev_out_valid_o = (state_q == ST_XFER) && dir_q;
  assign mem_req_o       = (state_q == ST_MEM);
  assign mem_we_o        = !dir_q;
endmodule

// File: rtl/dma_res_buf.sv
module dma_res_buf
  import dma_res_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              dev_in_valid_i,
  input  logic [15:0]       dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [15:0]       dev_out_data_o,
  input  logic              dev_out_ready_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [63:0]       mem_wdata_o,
  input  logic [63:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              done_o
);
  logic [BLK_W-1:0]  res;
  logic [PTR_W-1:0]  ptr;
  logic [ADDR_W-1:0] blk_addr;
  logic [LEN_W-1:0]  len;
  logic              busy, dir, hw_we, blk_we;
  logic              wr_ok;
  logic [1:0]        sw_res_we;

  assign wr_ok     = reg_we_i && !busy;
  assign sw_res_we = {wr_ok && reg_addr_i == REG_RES_HI,
                      wr_ok && reg_addr_i == REG_RES_LO};

  dma_res_store i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (sw_res_we),
    .sw_wdata_i (reg_wdata_i),
    .hw_we_i    (hw_we),
    .hw_idx_i   (ptr),
    .hw_data_i  (dev_in_data_i),
    .blk_we_i   (blk_we),
    .blk_data_i (mem_rdata_i),
    .res_o      (res)
  );

  dma_res_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (wr_ok && reg_addr_i == REG_CTRL && reg_wdata_i[0]),
    .dir_i           (reg_wdata_i[1]),
    .ptr_we_i        (wr_ok && reg_addr_i == REG_PTR),
    .ptr_wdata_i     (reg_wdata_i[PTR_W-1:0]),
    .addr_we_i       (wr_ok && reg_addr_i == REG_ADDR),
    .addr_wdata_i    (reg_wdata_i[ADDR_W-1:BLK_OFF]),
    .len_we_i        (wr_ok && reg_addr_i == REG_LEN),
    .len_wdata_i     (reg_wdata_i[LEN_W-1:0]),
    .dev_in_valid_i  (dev_in_valid_i),
    .dev_out_ready_i (dev_out_ready_i),
    .mem_ack_i       (mem_ack_i),
    .busy_o          (busy),
    .dir_o           (dir),
    .done_o          (done_o),
    .ptr_o           (ptr),
    .blk_addr_o      (blk_addr),
    .len_o           (len),
    .hw_we_o         (hw_we),
    .blk_we_o        (blk_we),
    .dev_in_ready_o  (dev_in_ready_o),
    .dev_out_valid_o (dev_out_valid_o),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o)
  );

  assign dev_out_data_o = res[{ptr, 4'b0000} +: HW_W];
  assign mem_addr_o     = blk_addr;
  assign mem_wdata_o    = res;

  always_comb begin
    unique case (reg_addr_i)
      REG_RES_LO: reg_rdata_o = res[31:0];
      REG_RES_HI: reg_rdata_o = res[63:32];
      REG_PTR:    reg_rdata_o = 32'(ptr);
      REG_ADDR:   reg_rdata_o = 32'(blk_addr);
      REG_LEN:    reg_rdata_o = 32'(len);
      REG_CTRL:   reg_rdata_o = {29'd0, done_o, dir, busy};
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_res_buf_chk.sv
module dma_res_buf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              dev_in_ready_o,
  input logic              dev_out_valid_o,
  input logic [15:0]       dev_out_data_o,
  input logic              dev_out_ready_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [63:0]       mem_wdata_o,
  input logic              mem_ack_i,
  input logic              done_o
);
  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r3_blk_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[2:0] == 3'b000);

  a_r3_stream_paused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !dev_in_ready_o && !dev_out_valid_o);

  a_r5_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_out_valid_o && !dev_out_ready_i |=> dev_out_valid_o && $stable(dev_out_data_o));

  a_r7_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && !dev_in_ready_o && !dev_out_valid_o);

  a_r7_done_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !(reg_we_i && reg_addr_i == 3'd5 && reg_wdata_i[0]) |=> done_o);

  a_r2_one_direction: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dev_in_ready_o && dev_out_valid_o));
endmodule

bind dma_res_buf dma_res_buf_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_wdata_i     (reg_wdata_i),
  .dev_in_ready_o  (dev_in_ready_o),
  .dev_out_valid_o (dev_out_valid_o),
  .dev_out_data_o  (dev_out_data_o),
  .dev_out_ready_i (dev_out_ready_i),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_ack_i       (mem_ack_i),
  .done_o          (done_o)
);

// File: tb/test_dma_res_buf.sv
`timescale 1ns/100ps
module test_dma_res_buf;
  localparam int AW = 12;
  localparam int LW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic          dev_in_valid_i = 1'b0;
  logic [15:0]   dev_in_data_i = '0;
  logic          dev_in_ready_o;
  logic          dev_out_valid_o;
  logic [15:0]   dev_out_data_o;
  logic          dev_out_ready_i = 1'b0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [63:0]   mem_wdata_o;
  logic [63:0]   mem_rdata_i = '0;
  logic          mem_ack_i = 1'b0;
  logic          done_o;

  always #2.5 clk = ~clk;

  dma_res_buf #(.ADDR_W(AW), .LEN_W(LW)) i_dma_res_buf (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .dev_in_valid_i(dev_in_valid_i), .dev_in_data_i(dev_in_data_i),
    .dev_in_ready_o(dev_in_ready_o), .dev_out_valid_o(dev_out_valid_o),
    .dev_out_data_o(dev_out_data_o), .dev_out_ready_i(dev_out_ready_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
    .done_o(done_o)
  );

  // behavioural reference state
  logic [15:0]   m_res [4];
  logic [1:0]    m_ptr;
  logic [AW-1:0] m_addr;
  int            m_len, m_cnt;
  bit            m_busy, m_mem, m_dir, m_done;
  logic [63:0]   mem_arr [64];
  int            seq, rd_cnt, wr_cnt;
  logic [15:0]   outq [$];
  int            nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_res[1], m_res[0]};
      3'd1: return {m_res[3], m_res[2]};
      3'd2: return 32'(m_ptr);
      3'd3: return 32'(m_addr);
      3'd4: return 32'(m_len);
      3'd5: return {29'd0, m_done, m_dir, m_busy};
      default: return 32'd0;
    endcase
  endfunction

  task automatic tick(input bit we = 1'b0, input logic [2:0] a = 3'd0, input logic [31:0] d = 32'd0);
    @(negedge clk);
    reg_we_i        = we;
    reg_addr_i      = a;
    reg_wdata_i     = d;
    dev_in_valid_i  = ($urandom_range(0, 3) != 0);
    dev_out_ready_i = ($urandom_range(0, 3) != 0);
    mem_ack_i       = ($urandom_range(0, 2) == 0);
    dev_in_data_i   = 16'hA000 + 16'(seq);
    mem_rdata_i     = mem_arr[mem_addr_o[8:3]];
    #1;
    chk(dev_in_ready_o == (m_busy && !m_mem && !m_dir), "R2 in_ready", 64'(dev_in_ready_o), 64'(m_busy && !m_mem && !m_dir));
    chk(dev_out_valid_o == (m_busy && !m_mem && m_dir), "R5 out_valid", 64'(dev_out_valid_o), 64'(m_busy && !m_mem && m_dir));
    if (m_busy && !m_mem && m_dir)
      chk(dev_out_data_o == m_res[m_ptr], "R5 out_data", 64'(dev_out_data_o), 64'(m_res[m_ptr]));
    chk(mem_req_o == (m_busy && m_mem), "R3 mem_req", 64'(mem_req_o), 64'(m_busy && m_mem));
    if (m_busy && m_mem) begin
      chk(mem_we_o == !m_dir, "R6 mem_we", 64'(mem_we_o), 64'(!m_dir));
      chk(mem_addr_o == m_addr, "R10 mem_addr", 64'(mem_addr_o), 64'(m_addr));
      if (!m_dir)
        chk(mem_wdata_o == {m_res[3], m_res[2], m_res[1], m_res[0]}, "R3 mem_wdata",
            mem_wdata_o, {m_res[3], m_res[2], m_res[1], m_res[0]});
    end
    chk(done_o == m_done, "R7 done", 64'(done_o), 64'(m_done));
    // advance the model over the coming edge
    if (we && !m_busy) begin
      case (a)
        3'd0: begin m_res[0] = d[15:0]; m_res[1] = d[31:16]; end
        3'd1: begin m_res[2] = d[15:0]; m_res[3] = d[31:16]; end
        3'd2: m_ptr = d[1:0];
        3'd3: m_addr = d[AW-1:0] & ~AW'(7);
        3'd4: m_len = int'(d[LW-1:0]);
        3'd5: if (d[0]) begin
          m_dir = d[1];
          m_cnt = m_len;
          m_done = (m_len == 0);
          m_busy = (m_len != 0);
          m_mem = 1'b0;
        end
        default: ;
      endcase
    end else if (m_busy && !m_mem) begin
      if (!m_dir && dev_in_valid_i) begin
        m_res[m_ptr] = dev_in_data_i;
        seq++;
        m_cnt--;
        if (m_ptr == 2'd3) m_mem = 1'b1;
        else if (m_cnt == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        m_ptr = m_ptr + 2'd1;
      end else if (m_dir && dev_out_ready_i) begin
        outq.push_back(dev_out_data_o);
        m_cnt--;
        if (m_cnt == 0) begin m_busy = 1'b0; m_done = 1'b1; end
        else if (m_ptr == 2'd3) m_mem = 1'b1;
        m_ptr = m_ptr + 2'd1;
      end
    end else if (m_busy && m_mem && mem_ack_i) begin
      if (!m_dir) begin
        mem_arr[m_addr[8:3]] = {m_res[3], m_res[2], m_res[1], m_res[0]};
        wr_cnt++;
        if (m_cnt == 0) begin m_busy = 1'b0; m_done = 1'b1; end
      end else begin
        for (int i = 0; i < 4; i++) m_res[i] = mem_rdata_i[i*16 +: 16];
        rd_cnt++;
      end
      m_mem = 1'b0;
      m_addr = m_addr + AW'(8);
    end
    @(posedge clk);
  endtask

  task automatic sw_check(input logic [2:0] a, input logic [31:0] exp, input string req);
    #1;
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o == exp, req, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 6; a++) sw_check(3'(a), exp_rd(3'(a)), req);
  endtask

  task automatic run_xfer(input bit dir, input logic [1:0] p, input logic [AW-1:0] addr,
                          input int len, input logic [63:0] pre);
    tick(1'b1, 3'd0, pre[31:0]);
    tick(1'b1, 3'd1, pre[63:32]);
    tick(1'b1, 3'd2, 32'(p));
    tick(1'b1, 3'd3, 32'(addr));
    tick(1'b1, 3'd4, 32'(len));
    tick(1'b1, 3'd5, {30'd0, dir, 1'b1});
    for (int k = 0; k < 2000 && m_busy; k++) tick();
    if (m_busy) chk(1'b0, "R7 transfer hung", 64'd1, 64'd0);
    for (int k = 0; k < 3; k++) tick();
    read_all("R7 registers after done");
  endtask

  initial begin
    #900000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_res[i] = '0;
    m_ptr = '0; m_addr = '0; m_len = 0; m_cnt = 0;
    m_busy = 0; m_mem = 0; m_dir = 0; m_done = 0;
    seq = 0; rd_cnt = 0; wr_cnt = 0;
    for (int i = 0; i < 64; i++) mem_arr[i] = 64'hDEAD_0000_0000_0000 | 64'(i);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);

    // R1: reset values
    read_all("R1 reset register");
    chk(!mem_req_o && !dev_in_ready_o && !dev_out_valid_o && !done_o, "R1 reset outputs",
        {mem_req_o, dev_in_ready_o, dev_out_valid_o, done_o}, 64'd0);
    tick();

    // R2 R3 R4: device to memory, head at halfword 1, 8 halfwords
    seq = 0;
    run_xfer(1'b0, 2'd1, 12'h040, 8, 64'h4444_3333_2222_1111);
    chk(mem_arr[8] == 64'hA002_A001_A000_1111, "R3 head merge block", mem_arr[8], 64'hA002_A001_A000_1111);
    chk(mem_arr[9] == 64'hA006_A005_A004_A003, "R2 second block", mem_arr[9], 64'hA006_A005_A004_A003);
    chk(mem_arr[10] == 64'hDEAD_0000_0000_000A, "R4 tail not written", mem_arr[10], 64'hDEAD_0000_0000_000A);
    sw_check(3'd2, 32'd1, "R4 tail count");
    sw_check(3'd3, 32'h050, "R4 pending block address");
    sw_check(3'd0, 32'hA004_A007, "R4 tail residue");

    // R5 R6: memory to device, head at halfword 2, 5 halfwords
    mem_arr[16] = 64'h8883_8882_8881_8880;
    outq.delete();
    rd_cnt = 0;
    run_xfer(1'b1, 2'd2, 12'h080, 5, 64'h4444_3333_2222_1111);
    chk(outq.size() == 5, "R5 output count", 64'(outq.size()), 64'd5);
    if (outq.size() == 5) begin
      chk(outq[0] == 16'h3333, "R5 first from residue", 64'(outq[0]), 64'h3333);
      chk(outq[1] == 16'h4444, "R5 second from residue", 64'(outq[1]), 64'h4444);
      chk(outq[2] == 16'h8880, "R6 first fetched", 64'(outq[2]), 64'h8880);
      chk(outq[4] == 16'h8882, "R6 last fetched", 64'(outq[4]), 64'h8882);
    end
    chk(rd_cnt == 1, "R6 single fetch", 64'(rd_cnt), 64'd1);
    sw_check(3'd3, 32'h088, "R6 address after fetch");
    sw_check(3'd2, 32'd3, "R5 pointer at end");

    // R9: zero length
    rd_cnt = 0; wr_cnt = 0;
    run_xfer(1'b0, 2'd0, 12'h100, 0, 64'h0);
    chk(rd_cnt == 0 && wr_cnt == 0, "R9 no memory traffic", 64'(rd_cnt + wr_cnt), 64'd0);
    sw_check(3'd5, 32'h4, "R9 done without busy");

    // R8: writes while busy are dropped
    seq = 0;
    tick(1'b1, 3'd2, 32'd0);
    tick(1'b1, 3'd3, 32'h200);
    tick(1'b1, 3'd4, 32'd10);
    tick(1'b1, 3'd5, 32'd1);
    tick();
    tick(1'b1, 3'd2, 32'd3);
    tick(1'b1, 3'd4, 32'd33);
    tick(1'b1, 3'd5, 32'd3);
    for (int k = 0; k < 2000 && m_busy; k++) tick();
    tick();
    sw_check(3'd2, 32'd2, "R8 pointer write ignored");
    sw_check(3'd4, 32'd10, "R8 length write ignored");
    sw_check(3'd5, 32'h4, "R8 start ignored");

    // wrap of the block address and maximum length
    run_xfer(1'b0, 2'd3, 12'hFF0, 63, 64'h1234_5678_9ABC_DEF0);
    run_xfer(1'b1, 2'd1, 12'hFF8, 63, 64'h0F0E_0D0C_0B0A_0908);

    // random transfers
    for (int n = 0; n < 24; n++)
      run_xfer(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
               AW'($urandom_range(0, 4095)) & ~AW'(7), int'($urandom_range(1, 40)),
               {$urandom(), $urandom()});

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule